// File: doc/BRIEF.md
# MAC Learning and Forwarding Table

This block is the address table of one bridge instance. Each frame descriptor presents a source MAC, a destination MAC and the ingress port. The block looks the destination up and returns either a forward result carrying the stored egress index or a flood result. It also returns a path select that is derived from the address pair, so that the frame is spread over a group of up to 16 tunnel or port paths. In the same cycle it looks the source up and learns it in hardware. A new source is inserted, a known source is refreshed, and a source seen on a new port is moved to that port.

The table is hashed into buckets of two ways. A request reads one bucket for the destination and one bucket for the source, so each lookup costs at most two table reads. The result is registered one cycle after the request. A background ager visits one bucket on every AGE_DIV-th cycle without a request or host write. It clears the used flag of dynamic entries and removes dynamic entries whose flag was already clear. A host write port installs permanent entries, and the ager never removes these.

Top module: `mac_fdb`

## Requirements
- R1: A request whose destination is not in the table gives, one cycle later, res_valid_o=1, res_flood_o=1 and res_egress_o=0.
- R2: A request whose destination is in the table gives, one cycle later, res_flood_o=0 and res_egress_o equal to the stored egress index.
- R3: A request whose source is absent, with a free way in its bucket, inserts a dynamic entry that binds the source to req_port_i. A destination lookup issued on the next cycle or later finds this entry.
- R4: A request whose source is present with the same port changes no entry and leaves learn_ovf_o unchanged.
- R5: A request whose source is present with a different port updates a dynamic entry to the new port. Learning never changes the port of a static entry.
- R6: A request whose source is absent while both ways of its bucket are valid stores nothing and raises learn_ovf_o by one, saturating at its maximum. learn_ovf_o changes only on the cycle after a request.
- R7: A host write (host_we_i) installs host_mac_i with host_port_i as a static entry. When a learn targets the same bucket in the same cycle, the host write is kept and the learn is dropped without counting.
- R8: A dynamic entry with no source refresh is removed within 2*BUCKETS*AGE_DIV idle cycles. An entry that has just been learned survives its first ager visit. Static entries are never removed.
- R9: res_path_o is the XOR of all PATH_W-bit slices of (SA XOR DA), starting at bit 0, so equal address pairs always take the same path.
- R10: The bucket of a MAC is the XOR of all BKT_W-bit slices of the MAC, starting at bit 0. After reset the table is empty, res_valid_o=0 and learn_ovf_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Frame descriptor present |
| req_sa_i | input | 48 | Source MAC |
| req_da_i | input | 48 | Destination MAC |
| req_port_i | input | PORT_W | Ingress port or tunnel index |
| host_we_i | input | 1 | Install a static entry |
| host_mac_i | input | 48 | MAC of the static entry |
| host_port_i | input | PORT_W | Egress index of the static entry |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| res_flood_o | output | 1 | Destination unknown, flood to all ports |
| res_egress_o | output | PORT_W | Egress index on a hit, 0 on flood |
| res_path_o | output | PATH_W | Path chosen within the group |
| learn_ovf_o | output | CNT_W | Count of learns dropped because the bucket was full |

## Verification
Every table state shows at the ports through the destination lookup. A lost, misplaced or wrongly aged entry appears as a flood or a wrong egress index on the first request that names that MAC, one cycle after that request. A wrong victim choice in a full bucket appears in the same way, and so does a learn that wins over a host write. It also shows as an unexpected step of learn_ovf_o in the cycle after the request. An ager fault shows only after one or two sweep periods, so the bench waits past those windows before it probes.

// File: rtl/mac_fdb_pkg.sv
package mac_fdb_pkg;
  localparam int MAC_W  = 48;
  localparam int PORT_W = 4;

  typedef struct packed {
    logic              valid;
    logic              stat;
    logic              hit;
    logic [MAC_W-1:0]  mac;
    logic [PORT_W-1:0] port;
  } entry_t;
endpackage

// File: rtl/mac_fdb_fold.sv
module mac_fdb_fold #(
  parameter int IN_W  = 48,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  d_i,
  output logic [OUT_W-1:0] h_o
);
  localparam int NSL   = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PAD_W = NSL * OUT_W;

  logic [PAD_W-1:0] pad;
  assign pad = PAD_W'(d_i);

  always_comb begin
    h_o = '0;
    for (int i = 0; i < NSL; i++) h_o = h_o ^ pad[i*OUT_W +: OUT_W];
  end
endmodule

// File: rtl/mac_fdb_probe.sv
module mac_fdb_probe
  import mac_fdb_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  entry_t [WAYS-1:0] set_i,
  input  logic [MAC_W-1:0]  key_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic              free_o,
  output logic [WAY_W-1:0]  free_way_o
);
  logic [WAYS-1:0] match, empty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = set_i[w].valid && (set_i[w].mac == key_i);
    assign empty[w] = !set_i[w].valid;
  end

  // lowest way wins
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
      if (empty[w]) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/mac_fdb_ager.sv
module mac_fdb_ager #(
  parameter int BKT_W   = 4,
  parameter int AGE_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  output logic             step_o,
  output logic [BKT_W-1:0] ptr_o
);
  localparam int DIV_W = (AGE_DIV > 1) ? $clog2(AGE_DIV) : 1;

  logic [DIV_W-1:0] div_q;

  assign step_o = idle_i && (div_q == DIV_W'(AGE_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ptr_o <= '0;
    end else if (idle_i) begin
      if (step_o) begin
        div_q <= '0;
        ptr_o <= ptr_o + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mac_fdb.sv
module mac_fdb
  import mac_fdb_pkg::*;
#(
  parameter int BKT_W   = 4,
  parameter int WAYS    = 2,
  parameter int PATH_W  = 4,
  parameter int AGE_DIV = 4,
  parameter int CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [MAC_W-1:0]  req_sa_i,
  input  logic [MAC_W-1:0]  req_da_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic              host_we_i,
  input  logic [MAC_W-1:0]  host_mac_i,
  input  logic [PORT_W-1:0] host_port_i,
  output logic              res_valid_o,
  output logic              res_flood_o,
  output logic [PORT_W-1:0] res_egress_o,
  output logic [PATH_W-1:0] res_path_o,
  output logic [CNT_W-1:0]  learn_ovf_o
);
  localparam int BUCKETS = 1 << BKT_W;
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;

  entry_t [WAYS-1:0] tbl [BUCKETS];

  logic [BKT_W-1:0]  da_bkt, sa_bkt, h_bkt, age_ptr;
  logic [PATH_W-1:0] path_h;
  logic              da_hit, sa_hit, sa_free, h_hit, h_free;
  logic              da_free_unused;
  logic [WAY_W-1:0]  da_way, sa_way, sa_fway, h_hway, h_fway, h_way;
  logic [WAY_W-1:0]  da_fway_unused;
  logic              age_step, lrn_en;
  entry_t [WAYS-1:0] da_set, sa_set, h_set;

  mac_fdb_fold #(.IN_W(MAC_W), .OUT_W(BKT_W)) u_hda (.d_i(req_da_i), .h_o(da_bkt));
  mac_fdb_fold #(.IN_W(MAC_W), .OUT_W(BKT_W)) u_hsa (.d_i(req_sa_i), .h_o(sa_bkt));
  mac_fdb_fold #(.IN_W(MAC_W), .OUT_W(BKT_W)) u_hho (.d_i(host_mac_i), .h_o(h_bkt));
  mac_fdb_fold #(.IN_W(MAC_W), .OUT_W(PATH_W)) u_hpa (
    .d_i(req_sa_i ^ req_da_i), .h_o(path_h)
  );

  assign da_set = tbl[da_bkt];
  assign sa_set = tbl[sa_bkt];
  assign h_set  = tbl[h_bkt];

  mac_fdb_probe #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pda (
    .set_i(da_set), .key_i(req_da_i), .hit_o(da_hit), .hit_way_o(da_way),
    .free_o(da_free_unused), .free_way_o(da_fway_unused)
  );
  mac_fdb_probe #(.WAYS(WAYS), .WAY_W(WAY_W)) u_psa (
    .set_i(sa_set), .key_i(req_sa_i), .hit_o(sa_hit), .hit_way_o(sa_way),
    .free_o(sa_free), .free_way_o(sa_fway)
  );
  mac_fdb_probe #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pho (
    .set_i(h_set), .key_i(host_mac_i), .hit_o(h_hit), .hit_way_o(h_hway),
    .free_o(h_free), .free_way_o(h_fway)
  );

  mac_fdb_ager #(.BKT_W(BKT_W), .AGE_DIV(AGE_DIV)) u_ager (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(!req_valid_i && !host_we_i),
    .step_o(age_step), .ptr_o(age_ptr)
  );

  // host replaces its own MAC, else a free way, else way 0
  assign h_way  = h_hit ? h_hway : (h_free ? h_fway : '0);
  assign lrn_en = req_valid_i && !(host_we_i && (h_bkt == sa_bkt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BUCKETS; b++) tbl[b] <= '0;
      res_valid_o  <= 1'b0;
      res_flood_o  <= 1'b0;
      res_egress_o <= '0;
      res_path_o   <= '0;
      learn_ovf_o  <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        res_flood_o  <= !da_hit;
        res_egress_o <= da_hit ? da_set[da_way].port : '0;
        res_path_o   <= path_h;
      end

      if (age_step) begin
        for (int w = 0; w < WAYS; w++) begin
          if (tbl[age_ptr][w].valid && !tbl[age_ptr][w].stat) begin
            if (tbl[age_ptr][w].hit) tbl[age_ptr][w].hit   <= 1'b0;
            else                     tbl[age_ptr][w].valid <= 1'b0;
          end
        end
      end

      if (lrn_en) begin
        if (sa_hit) begin
          tbl[sa_bkt][sa_way].hit <= 1'b1;
          if (!sa_set[sa_way].stat) tbl[sa_bkt][sa_way].port <= req_port_i;
        end else if (sa_free) begin
          tbl[sa_bkt][sa_fway] <= '{valid: 1'b1, stat: 1'b0, hit: 1'b1,
                                    mac: req_sa_i, port: req_port_i};
        end else if (learn_ovf_o != '1) begin
          learn_ovf_o <= learn_ovf_o + 1'b1;
        end
      end

      if (host_we_i) begin
        tbl[h_bkt][h_way] <= '{valid: 1'b1, stat: 1'b1, hit: 1'b0,
                               mac: host_mac_i, port: host_port_i};
      end
    end
  end
endmodule

// File: rtl/mac_fdb_chk.sv
module mac_fdb_chk
  import mac_fdb_pkg::*;
#(
  parameter int PATH_W = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [MAC_W-1:0]  req_sa_i,
  input logic [MAC_W-1:0]  req_da_i,
  input logic              res_valid_o,
  input logic              res_flood_o,
  input logic [PORT_W-1:0] res_egress_o,
  input logic [PATH_W-1:0] res_path_o,
  input logic [CNT_W-1:0]  learn_ovf_o
);
  assert_flood_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_flood_o) |-> (res_egress_o == '0));

  assert_lat_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);

  assert_lat_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);

  assert_ovf_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (learn_ovf_o == $past(learn_ovf_o)) ||
             (learn_ovf_o == CNT_W'($past(learn_ovf_o) + 1'b1)));

  assert_ovf_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(learn_ovf_o));

  assert_path_same_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && $past(req_valid_i) && (req_sa_i == $past(req_sa_i)) &&
     (req_da_i == $past(req_da_i))) |=> (res_path_o == $past(res_path_o)));
endmodule

bind mac_fdb mac_fdb_chk #(.PATH_W(PATH_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_sa_i(req_sa_i), .req_da_i(req_da_i), .res_valid_o(res_valid_o),
  .res_flood_o(res_flood_o), .res_egress_o(res_egress_o),
  .res_path_o(res_path_o), .learn_ovf_o(learn_ovf_o)
);

// File: tb/tb_mac_fdb.sv
`timescale 1ns/1ps
module tb_mac_fdb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [47:0] req_sa_i = '0, req_da_i = '0;
  logic [3:0]  req_port_i = '0;
  logic        host_we_i = 1'b0;
  logic [47:0] host_mac_i = '0;
  logic [3:0]  host_port_i = '0;
  logic        res_valid_o, res_flood_o;
  logic [3:0]  res_egress_o, res_path_o;
  logic [7:0]  learn_ovf_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mac_fdb dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_sa_i(req_sa_i), .req_da_i(req_da_i), .req_port_i(req_port_i),
    .host_we_i(host_we_i), .host_mac_i(host_mac_i), .host_port_i(host_port_i),
    .res_valid_o(res_valid_o), .res_flood_o(res_flood_o),
    .res_egress_o(res_egress_o), .res_path_o(res_path_o),
    .learn_ovf_o(learn_ovf_o)
  );

  function automatic logic [3:0] fold4(logic [47:0] m);
    logic [3:0] r = '0;
    for (int i = 0; i < 12; i++) r = r ^ m[i*4 +: 4];
    return r;
  endfunction

  function automatic logic [47:0] mk_mac(logic [43:0] tag, logic [3:0] b);
    logic [47:0] base = {tag, 4'h0};
    return base | {44'h0, fold4(base) ^ b};
  endfunction

  localparam logic [47:0] PRB = 48'h0A0B0C0D0E00 | 48'(4'hF ^ fold4(48'h0A0B0C0D0E00));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered on the next posedge
  task automatic req(logic [47:0] sa, logic [47:0] da, logic [3:0] p);
    @(negedge clk);
    req_valid_i = 1'b1; req_sa_i = sa; req_da_i = da; req_port_i = p;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic host(logic [47:0] m, logic [3:0] p);
    @(negedge clk);
    host_we_i = 1'b1; host_mac_i = m; host_port_i = p;
    @(negedge clk);
    host_we_i = 1'b0;
  endtask

  task automatic lookup_hit(string r, logic [47:0] da, logic [3:0] p);
    req(PRB, da, 4'h0);
    chk({r, " valid"}, 64'(res_valid_o), 1);
    chk({r, " flood"}, 64'(res_flood_o), 0);
    chk({r, " egress"}, 64'(res_egress_o), 64'(p));
  endtask

  task automatic lookup_miss(string r, logic [47:0] da);
    req(PRB, da, 4'h0);
    chk({r, " valid"}, 64'(res_valid_o), 1);
    chk({r, " flood"}, 64'(res_flood_o), 1);
    chk({r, " egress"}, 64'(res_egress_o), 0);
  endtask

  task automatic t_reset();
    chk("R10 reset valid", 64'(res_valid_o), 0);
    chk("R10 reset ovf", 64'(learn_ovf_o), 0);
  endtask

  task automatic t_flood();
    logic [47:0] d = mk_mac(44'h11, 4'h3);
    lookup_miss("R1 unknown da", d);
    chk("R9 path on flood", 64'(res_path_o), 64'(fold4(PRB ^ d)));
  endtask

  task automatic t_learn();
    logic [47:0] a = mk_mac(44'h21, 4'h1);
    req(a, mk_mac(44'h99, 4'h3), 4'h3);
    lookup_hit("R3 learned", a, 4'h3);
    lookup_hit("R2 second lookup", a, 4'h3);
    req(a, mk_mac(44'h99, 4'h3), 4'h3);
    chk("R4 ovf unchanged", 64'(learn_ovf_o), 0);
    lookup_hit("R4 same port kept", a, 4'h3);
    req(a, mk_mac(44'h99, 4'h3), 4'h6);
    lookup_hit("R5 station move", a, 4'h6);
  endtask

  task automatic t_static();
    logic [47:0] h = mk_mac(44'h31, 4'h2);
    host(h, 4'h9);
    lookup_hit("R7 host install", h, 4'h9);
    req(h, mk_mac(44'h99, 4'h3), 4'h1);
    lookup_hit("R5 static not moved", h, 4'h9);
  endtask

  task automatic t_overflow();
    logic [47:0] m0 = mk_mac(44'h41, 4'h5);
    logic [47:0] m1 = mk_mac(44'h42, 4'h5);
    logic [47:0] m2 = mk_mac(44'h43, 4'h5);
    req(m0, mk_mac(44'h99, 4'h3), 4'h1);
    req(m1, mk_mac(44'h99, 4'h3), 4'h2);
    chk("R6 no ovf yet", 64'(learn_ovf_o), 0);
    req(m2, mk_mac(44'h99, 4'h3), 4'h4);
    chk("R6 ovf count", 64'(learn_ovf_o), 1);
    lookup_miss("R6 dropped", m2);
    lookup_hit("R6 way0 kept", m0, 4'h1);
    lookup_hit("R6 way1 kept", m1, 4'h2);
  endtask

  task automatic t_host_prio();
    logic [47:0] h = mk_mac(44'h51, 4'h9);
    logic [47:0] l = mk_mac(44'h52, 4'h9);
    @(negedge clk);
    host_we_i = 1'b1; host_mac_i = h; host_port_i = 4'hC;
    req_valid_i = 1'b1; req_sa_i = l; req_da_i = mk_mac(44'h99, 4'h3); req_port_i = 4'h7;
    @(negedge clk);
    host_we_i = 1'b0; req_valid_i = 1'b0;
    chk("R7 collision not counted", 64'(learn_ovf_o), 1);
    lookup_hit("R7 host kept", h, 4'hC);
    lookup_miss("R7 learn dropped", l);
  endtask

  task automatic t_path();
    logic [47:0] s = 48'h123456789ABC, d = 48'hFEDCBA987654;
    req(s, d, 4'h0);
    chk("R9 path a", 64'(res_path_o), 64'(fold4(s ^ d)));
    req(s, d, 4'h0);
    chk("R9 path repeat", 64'(res_path_o), 64'(fold4(s ^ d)));
    req(s, 48'h000000000003, 4'h0);
    chk("R9 path b", 64'(res_path_o), 64'(fold4(s ^ 48'h3)));
  endtask

  task automatic t_aging();
    logic [47:0] a = mk_mac(44'h61, 4'h7);
    logic [47:0] h = mk_mac(44'h31, 4'h2);
    req(a, mk_mac(44'h99, 4'h3), 4'h8);
    repeat (40) @(negedge clk);
    lookup_hit("R8 survives first visit", a, 4'h8);
    repeat (300) @(negedge clk);
    lookup_miss("R8 aged out", a);
    lookup_hit("R8 static kept", h, 4'h9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_flood();
    t_learn();
    t_static();
    t_overflow();
    t_host_prio();
    t_path();
    t_aging();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule